// File: doc/BRIEF.md
# Logarithmic Multiply Accumulator with Exponent-Indexed Exact Sum

This block multiplies pairs of 8-bit logarithmic numbers and sums the products exactly. Each operand holds a sign bit and a 7-bit unsigned fixed-point base-2 logarithm. The upper four bits of that logarithm are the integer part and the lower three bits are the fraction. Because the operands are logarithms, the product is formed by adding the two magnitudes. An eight-entry table then turns the 3-bit fraction of that sum into a linear 8-bit mantissa. The 5-bit integer part of the sum chooses one of 32 signed partial-sum registers. The signed mantissa is added into the chosen register in the same cycle, so one product is taken in on every clock.

When a reconstruction is requested, the block walks the 32 partial sums from exponent 0 upward. It adds each one into a narrow accumulator and shifts one result bit out per cycle, least significant bit first. At the end it presents the remaining upper bits of the result. Each partial sum is cleared as it is read, so the next accumulation starts from zero. The serial bits and the final upper word together form the exact sum S = Σ ±m·2^e. The real value is S / 128.

Top module: `logmac_acc`

## Requirements
- R1: An operand code of 8'h00 stands for zero. A product with either operand equal to 8'h00 leaves every partial sum unchanged. Code 8'h80 is not zero: it stands for -1.0.
- R2: The product is negative exactly when bit 7 of the two operands differ.
- R3: Let t be the 8-bit sum of the operands' bits [6:0]. The exponent is e = t[7:3], with values 0 to 31. The mantissa is m = round(2^(f/8)·128), where f = t[2:0]. This gives the values 128, 140, 152, 166, 181, 197, 215 and 235. The signed product ±m·2^e is added to the running sum.
- R4: A product is taken in on every cycle in which in_valid is high and busy is low, including cycles back to back.
- R5: A recon_start pulse while the block is idle starts a readout. From the second cycle after the pulse, bit_valid is high for exactly 32 cycles. These cycles carry bits 0 to 31 of S in order. The last of them also raises done for one cycle. result_hi then holds S arithmetically shifted right by 32, in 22-bit two's complement.
- R6: While busy is high, in_valid is ignored. No product presented then appears in any later result.
- R7: A readout leaves all partial sums at zero. A readout with no products taken in since the previous one gives S = 0.
- R8: A recon_start pulse while busy is high has no effect. The current readout still gives exactly 32 bits and one done pulse.
- R9: After reset, busy, bit_valid and done are low and all partial sums are zero.
- R10: A product taken in during the same cycle as the recon_start pulse that begins a readout is included in that readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| op_a | input | 8 | First logarithmic operand |
| op_b | input | 8 | Second logarithmic operand |
| recon_start | input | 1 | Begin a readout of the sum |
| busy | output | 1 | Readout in progress |
| bit_valid | output | 1 | bit_out carries a result bit |
| bit_out | output | 1 | Serial result bit, least significant first |
| done | output | 1 | One-cycle pulse with the last result bit |
| result_hi | output | 22 | Sum shifted right by 32, two's complement |

## Verification
The bench builds the block with the default of 12 guard bits. With this setting the partial sums are 21 bits wide and the final accumulator is 22 bits wide. Operands as large as 8'h7F reach exponent 31, so both the highest partial-sum slot and the upper result word are exercised. A run of 40 equal products on one exponent, followed by opposite-sign cancellation, checks that guard growth and negative partial sums carry correctly.

// File: rtl/logmac_pkg.sv
package logmac_pkg;
    localparam int INT_W   = 4;
    localparam int FRAC_W  = 3;
    localparam int MAG_W   = INT_W + FRAC_W;
    localparam int LOG_W   = 1 + MAG_W;
    localparam int EXP_W   = INT_W + 1;
    localparam int NUM_EXP = 2 ** EXP_W;
    localparam int MANT_FB = 7;
    localparam int MANT_W  = MANT_FB + 1;

    typedef logic [LOG_W-1:0]  lnum_t;
    typedef logic [EXP_W-1:0]  exp_t;
    typedef logic [MANT_W-1:0] mant_t;

    typedef struct packed {
        logic  valid;
        logic  neg;
        exp_t  exp;
        mant_t mant;
    } prod_t;

    typedef enum logic {RC_IDLE, RC_RUN} rc_state_t;

    // round(2^(f/8) * 128)
    function automatic mant_t frac_to_mant(input logic [FRAC_W-1:0] f);
        mant_t m;
        case (f)
            3'd0:    m = 8'd128;
            3'd1:    m = 8'd140;
            3'd2:    m = 8'd152;
            3'd3:    m = 8'd166;
            3'd4:    m = 8'd181;
            3'd5:    m = 8'd197;
            3'd6:    m = 8'd215;
            default: m = 8'd235;
        endcase
        return m;
    endfunction

    function automatic logic is_zero(input lnum_t x);
        return x == '0;
    endfunction
endpackage

// File: rtl/logmac_mul.sv
module logmac_mul
    import logmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  lnum_t a,
    input  lnum_t b,
    output prod_t prod
);
    logic [MAG_W:0] lsum;

    always_comb begin
        lsum      = {1'b0, a[MAG_W-1:0]} + {1'b0, b[MAG_W-1:0]};
        prod.valid = valid && !is_zero(a) && !is_zero(b);
        prod.neg   = a[LOG_W-1] ^ b[LOG_W-1];
        prod.exp   = lsum[MAG_W:FRAC_W];
        prod.mant  = frac_to_mant(lsum[FRAC_W-1:0]);
    end

    // R1
    zero_suppress_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (a == '0 || b == '0)) |-> !prod.valid);

    // R3
    mant_norm_chk: assert property (@(posedge clk) disable iff (rst)
        prod.valid |-> prod.mant[MANT_W-1]);
endmodule

// File: rtl/logmac_bank.sv
module logmac_bank
    import logmac_pkg::*;
#(
    parameter int PSUM_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  exp_t              acc_idx,
    input  logic              acc_neg,
    input  mant_t             acc_mant,
    input  exp_t              rd_idx,
    input  logic              clr_en,
    output logic [PSUM_W-1:0] rd_data
);
    logic signed [PSUM_W-1:0] cells [NUM_EXP];
    logic signed [PSUM_W-1:0] mag;
    logic signed [PSUM_W-1:0] delta;

    always_comb begin
        mag   = $signed({{(PSUM_W-MANT_W){1'b0}}, acc_mant});
        delta = acc_neg ? -mag : mag;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_EXP; i++) begin
            if (rst) begin
                cells[i] <= '0;
            end else if (clr_en && rd_idx == exp_t'(i)) begin
                cells[i] <= '0;
            end else if (acc_en && acc_idx == exp_t'(i)) begin
                cells[i] <= cells[i] + delta;
            end
        end
    end

    assign rd_data = cells[rd_idx];

    // R6
    no_acc_during_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_en && clr_en));
endmodule

// File: rtl/logmac_recon.sv
module logmac_recon
    import logmac_pkg::*;
#(
    parameter int PSUM_W = 21,
    parameter int ACC_W  = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PSUM_W-1:0] psum,
    output exp_t              rd_idx,
    output logic              clr_en,
    output logic              busy,
    output logic              bit_valid,
    output logic              bit_out,
    output logic              done,
    output logic [ACC_W-1:0]  result_hi
);
    localparam exp_t LAST_IDX = exp_t'(NUM_EXP - 1);

    rc_state_t        state;
    exp_t             idx;
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   step;

    always_comb begin
        step = {acc[ACC_W-1], acc} + {{(ACC_W+1-PSUM_W){psum[PSUM_W-1]}}, psum};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RC_IDLE;
            idx       <= '0;
            acc       <= '0;
            bit_valid <= 1'b0;
            bit_out   <= 1'b0;
            done      <= 1'b0;
            result_hi <= '0;
        end else begin
            bit_valid <= 1'b0;
            done      <= 1'b0;
            case (state)
                RC_IDLE: begin
                    if (start) begin
                        state <= RC_RUN;
                        idx   <= '0;
                        acc   <= '0;
                    end
                end
                default: begin
                    bit_valid <= 1'b1;
                    bit_out   <= step[0];
                    acc       <= step[ACC_W:1];
                    idx       <= idx + 1'b1;
                    if (idx == LAST_IDX) begin
                        state     <= RC_IDLE;
                        done      <= 1'b1;
                        result_hi <= step[ACC_W:1];
                    end
                end
            endcase
        end
    end

    assign rd_idx = idx;
    assign clr_en = (state == RC_RUN);
    assign busy   = (state == RC_RUN);

    // R5
    done_with_bit_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> bit_valid);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    idx_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST_IDX) |=> (busy && idx == exp_t'($past(idx) + 1'b1)));
endmodule

// File: rtl/logmac_acc.sv
module logmac_acc
    import logmac_pkg::*;
#(
    parameter  int GUARD_W = 12,
    localparam int PSUM_W  = MANT_W + 1 + GUARD_W,
    localparam int ACC_W   = PSUM_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       op_a,
    input  logic [7:0]       op_b,
    input  logic             recon_start,
    output logic             busy,
    output logic             bit_valid,
    output logic             bit_out,
    output logic             done,
    output logic [ACC_W-1:0] result_hi
);
    prod_t             prod;
    exp_t              rd_idx;
    logic              clr_en;
    logic [PSUM_W-1:0] psum;
    logic              acc_en;

    logmac_mul u_mul (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .a     (lnum_t'(op_a)),
        .b     (lnum_t'(op_b)),
        .prod  (prod)
    );

    assign acc_en = prod.valid && !busy;

    logmac_bank #(.PSUM_W(PSUM_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .acc_en   (acc_en),
        .acc_idx  (prod.exp),
        .acc_neg  (prod.neg),
        .acc_mant (prod.mant),
        .rd_idx   (rd_idx),
        .clr_en   (clr_en),
        .rd_data  (psum)
    );

    logmac_recon #(.PSUM_W(PSUM_W), .ACC_W(ACC_W)) u_recon (
        .clk       (clk),
        .rst       (rst),
        .start     (recon_start),
        .psum      (psum),
        .rd_idx    (rd_idx),
        .clr_en    (clr_en),
        .busy      (busy),
        .bit_valid (bit_valid),
        .bit_out   (bit_out),
        .done      (done),
        .result_hi (result_hi)
    );
endmodule

// File: tb/logmac_acc_tb.sv
module logmac_acc_tb;
    localparam int ACC_W = 22;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       op_a = '0;
    logic [7:0]       op_b = '0;
    logic             recon_start = 1'b0;
    logic             busy, bit_valid, bit_out, done;
    logic [ACC_W-1:0] result_hi;

    int    errs = 0;
    int    checks = 0;
    longint model_s = 0;

    always #2 clk = ~clk;

    logmac_acc u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .recon_start(recon_start), .busy(busy), .bit_valid(bit_valid),
        .bit_out(bit_out), .done(done), .result_hi(result_hi)
    );

    function automatic longint prod_val(input logic [7:0] a, input logic [7:0] b);
        int t, e, f, m;
        longint v;
        if (a == 8'h00 || b == 8'h00) return 0;
        t = int'(a[6:0]) + int'(b[6:0]);
        e = t / 8;
        f = t % 8;
        m = $rtoi((2.0 ** (real'(f) / 8.0)) * 128.0 + 0.5);
        v = longint'(m) << e;
        return (a[7] ^ b[7]) ? -v : v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a;
        op_b = b;
        model_s += prod_val(a, b);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic readout(input string tag, input bit junk, input bit with_prod,
                           input logic [7:0] a, input logic [7:0] b);
        longint expv, got;
        int nbits, ndone;
        logic [ACC_W-1:0] hi;
        @(negedge clk);
        recon_start = 1'b1;
        if (with_prod) begin
            in_valid = 1'b1;
            op_a = a;
            op_b = b;
            model_s += prod_val(a, b);
        end else begin
            in_valid = 1'b0;
        end
        expv = model_s;
        model_s = 0;
        @(negedge clk);
        recon_start = 1'b0;
        in_valid = 1'b0;
        nbits = 0; ndone = 0; got = 0; hi = '0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (bit_valid) begin
                if (nbits < 64) got[nbits] = bit_out;
                nbits++;
            end
            if (done) begin
                ndone++;
                hi = result_hi;
            end
            if (junk && c >= 2 && c < 8) begin
                in_valid = 1'b1;
                op_a = 8'h3C;
                op_b = 8'h21;
            end else begin
                in_valid = 1'b0;
            end
            recon_start = junk && (c == 10);
        end
        in_valid = 1'b0;
        recon_start = 1'b0;
        check({tag, " bit count"}, nbits, 32);
        check({tag, " done pulses"}, ndone, 1);
        check({tag, " low bits"}, longint'(got[31:0]), longint'(expv[31:0]));
        check({tag, " result_hi"}, longint'($signed(hi)), expv >>> 32);
    endtask

    initial begin
        #800000;
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 busy", busy, 0);
        check("R9 bit_valid", bit_valid, 0);
        check("R9 done", done, 0);
        readout("R9 empty bank", 0, 0, 8'h00, 8'h00);

        // R3 single product, exponent 2, mantissa 128
        push(8'h08, 8'h08);
        idle();
        readout("R3 single", 0, 0, 8'h00, 8'h00);

        // R2 sign combinations
        push(8'h88, 8'h08);
        push(8'h88, 8'h91);
        push(8'h0B, 8'hA4);
        idle();
        readout("R2 signs", 0, 0, 8'h00, 8'h00);

        // R1 zero codes suppressed, 8'h80 is -1.0
        push(8'h00, 8'h7F);
        push(8'h55, 8'h00);
        push(8'h80, 8'h19);
        push(8'h00, 8'h00);
        idle();
        readout("R1 zeros", 0, 0, 8'h00, 8'h00);

        // R4 R3 back-to-back mix covering all fractions and top exponent
        for (int i = 0; i < 24; i++) push(8'((i * 37 + 5) & 255), 8'((i * 91 + 3) & 255));
        push(8'h7F, 8'h7F);
        push(8'hFF, 8'h7E);
        push(8'h7F, 8'h78);
        idle();
        readout("R4 stream", 0, 0, 8'h00, 8'h00);

        // R3 guard growth on one exponent and cancellation
        for (int i = 0; i < 40; i++) push(8'h7F, 8'h7F);
        for (int i = 0; i < 15; i++) push(8'hFF, 8'h7F);
        idle();
        readout("R3 guard", 0, 0, 8'h00, 8'h00);

        // R6 R8 inputs and start while busy are ignored
        push(8'h21, 8'h42);
        idle();
        readout("R8 start while busy", 1, 0, 8'h00, 8'h00);
        readout("R6 ignored inputs", 0, 0, 8'h00, 8'h00);

        // R7 back-to-back readouts without inputs
        push(8'h63, 8'h5D);
        idle();
        readout("R7 first", 0, 0, 8'h00, 8'h00);
        readout("R7 cleared", 0, 0, 8'h00, 8'h00);

        // R10 product in start cycle included
        push(8'h12, 8'h34);
        readout("R10 start cycle", 0, 1, 8'hC5, 8'h27);
        readout("R10 after", 0, 0, 8'h00, 8'h00);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule